// File: doc/BRIEF.md
# I2C Bus Condition Qualifier

This block watches the clock and data lines of an I2C bus and decides when a START or a STOP condition has really occurred. Both lines are first brought into the system clock domain. An SDA edge seen while SCL is high becomes a candidate. It is accepted only if three timing measures, all counted in system clock cycles, clear their thresholds. The three measures are how long SCL had been high before the edge, how long SDA had been stable before the edge, and how long SCL stays high with SDA unchanged after the edge.

A mode input picks one of two threshold sets: a slow set for standard bus timing and a short set for high-speed timing. An accepted START produces a one-cycle pulse and marks the bus as busy. An accepted STOP produces a one-cycle pulse and marks the bus as free. When the local controller is not bus master, an accepted STOP also raises an interrupt request. That request stays raised until software acknowledges it.

Top module: `i2c_cond_detect`

## Requirements
- R1: While reset is held and just after it is released, `start_pulse`, `stop_pulse`, `bus_busy` and `irq` are all 0.
- R2: An SDA falling edge while SCL is high, once fully qualified, gives exactly one cycle of `start_pulse`.
- R3: An SDA rising edge while SCL is high, once fully qualified, gives exactly one cycle of `stop_pulse`.
- R4: With `fast_mode`=0, a condition is accepted only if SCL was high for more than 26 cycles before the SDA edge. A candidate with about 18 cycles of SCL-high time is ignored.
- R5: With `fast_mode`=0, a condition is accepted only if SDA was stable for more than 13 cycles before its edge. A candidate with about 6 cycles of setup is ignored.
- R6: With `fast_mode`=0, SCL must stay high and SDA unchanged for more than 13 cycles after the edge. If SCL falls or SDA moves sooner, the candidate is dropped.
- R7: With `fast_mode`=1, the thresholds become more than 4 cycles of SCL-high time, more than 2 cycles of setup and more than 2 cycles of hold. A START with 8 cycles of SCL-high time is then accepted, and one with 2 cycles is not.
- R8: `bus_busy` goes to 1 in the same cycle as `start_pulse` and to 0 in the same cycle as `stop_pulse`. At all other times it keeps its value.
- R9: With `master_mode`=0, an accepted STOP sets `irq` in the same cycle as `stop_pulse`. `irq` then stays at 1 until a cycle with `irq_ack`=1 clears it. If an accepted STOP and `irq_ack` fall in the same cycle, the set wins.
- R10: With `master_mode`=1, an accepted STOP still clears `bus_busy` but leaves `irq` at 0.
- R11: `start_pulse` and `stop_pulse` are never high together.
- R12: SDA changes made while SCL is low, as in ordinary data bits, produce no pulse and do not change `bus_busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| fast_mode | input | 1 | 1 selects high-speed thresholds, 0 selects standard |
| master_mode | input | 1 | 1 when the local controller is bus master |
| irq_ack | input | 1 | Clears the interrupt request |
| start_pulse | output | 1 | One-cycle strobe for an accepted START |
| stop_pulse | output | 1 | One-cycle strobe for an accepted STOP |
| bus_busy | output | 1 | Bus-busy flag |
| irq | output | 1 | Interrupt request raised by a STOP in slave mode |

## Verification
The interrupt flag has two causes that can land in the same cycle: setting it for a newly accepted STOP and clearing it through `irq_ack`. The bench provokes this by holding `irq_ack` high for the whole STOP sequence. The cycle that shows `stop_pulse` must then also show `irq` at 1, and the cycle after it must show `irq` back at 0. The scoreboard carries both expectations with the STOP item, so the check does not depend on knowing the exact pulse cycle in advance.

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect #(
  parameter int STD_REL  = 26,
  parameter int STD_SU   = 13,
  parameter int STD_HD   = 13,
  parameter int FAST_REL = 4,
  parameter int FAST_SU  = 2,
  parameter int FAST_HD  = 2,
  parameter int SYNC     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic fast_mode,
  input  logic master_mode,
  input  logic irq_ack,
  output logic start_pulse,
  output logic stop_pulse,
  output logic bus_busy,
  output logic irq
);
  localparam int M_A  = STD_REL > STD_SU ? STD_REL : STD_SU;
  localparam int M_B  = STD_HD > FAST_REL ? STD_HD : FAST_REL;
  localparam int M_C  = FAST_SU > FAST_HD ? FAST_SU : FAST_HD;
  localparam int M_AB = M_A > M_B ? M_A : M_B;
  localparam int MAXT = M_AB > M_C ? M_AB : M_C;
  localparam int CW   = $clog2(MAXT + 2) + 1;

  logic [SYNC-1:0] scl_sh, sda_sh;
  logic            sda_d;
  logic [CW-1:0]   rel_cnt, su_cnt, hd_cnt;
  logic            pend, pend_stop;

  wire scl_s    = scl_sh[SYNC-1];
  wire sda_s    = sda_sh[SYNC-1];
  wire sda_edge = sda_s ^ sda_d;

  wire [CW-1:0] rel_th = fast_mode ? CW'(FAST_REL) : CW'(STD_REL);
  wire [CW-1:0] su_th  = fast_mode ? CW'(FAST_SU)  : CW'(STD_SU);
  wire [CW-1:0] hd_th  = fast_mode ? CW'(FAST_HD)  : CW'(STD_HD);

  wire qual      = scl_s && sda_edge && (rel_cnt > rel_th) && (su_cnt > su_th);
  wire hold_done = pend && scl_s && !sda_edge && (hd_cnt == hd_th);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC-2:0], scl_in};
      sda_sh <= {sda_sh[SYNC-2:0], sda_in};
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_cnt <= '0;
      su_cnt  <= '0;
    end else begin
      if (!scl_s)              rel_cnt <= '0;
      else if (rel_cnt != '1)  rel_cnt <= rel_cnt + 1'b1;
      if (sda_edge)            su_cnt  <= '0;
      else if (su_cnt != '1)   su_cnt  <= su_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_stop <= 1'b0;
      hd_cnt    <= '0;
    end else if (qual) begin
      pend      <= 1'b1;
      pend_stop <= sda_s;
      hd_cnt    <= '0;
    end else if (pend) begin
      if (!scl_s || sda_edge || hold_done) pend <= 1'b0;
      else                                 hd_cnt <= hd_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
      bus_busy    <= 1'b0;
      irq         <= 1'b0;
    end else begin
      start_pulse <= hold_done && !pend_stop;
      stop_pulse  <= hold_done && pend_stop;
      if (hold_done) bus_busy <= !pend_stop;
      if (hold_done && pend_stop && !master_mode) irq <= 1'b1;
      else if (irq_ack)                           irq <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_cond_detect_chk.sv
module i2c_cond_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic master_mode,
  input logic irq_ack,
  input logic start_pulse,
  input logic stop_pulse,
  input logic bus_busy,
  input logic irq
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(start_pulse && stop_pulse)); // R11
  AST_START_ONE: assert property (@(posedge clk) disable iff (!rst_n) start_pulse |=> !start_pulse); // R2
  AST_STOP_ONE: assert property (@(posedge clk) disable iff (!rst_n) stop_pulse |=> !stop_pulse); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start_pulse |-> bus_busy); // R8
  AST_STOP_FREE: assert property (@(posedge clk) disable iff (!rst_n) stop_pulse |-> !bus_busy); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!start_pulse && !stop_pulse) |-> $stable(bus_busy)); // R8
  AST_IRQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (irq && !irq_ack) |=> irq); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> (stop_pulse && !$past(master_mode))); // R10
endmodule

bind i2c_cond_detect i2c_cond_detect_chk u_chk (.*);

// File: tb/i2c_cond_detect_bench.sv
module i2c_cond_detect_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, fast = 1'b0, mst = 1'b0, ack = 1'b0;
  logic start_pulse, stop_pulse, bus_busy, irq;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R12";

  typedef struct {
    bit    is_stop;
    bit    busy;
    bit    irq_v;
    bit    chk_after;
    bit    irq_after;
    string req;
  } ev_t;
  ev_t exp_q[$];
  bit  after_pend = 0;
  bit  after_val  = 0;

  i2c_cond_detect u_i2c_cond_detect (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .fast_mode(fast), .master_mode(mst), .irq_ack(ack),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .bus_busy(bus_busy), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(bit st, bit busy, bit iv, bit ca, bit ia, string req);
    ev_t e;
    e.is_stop = st; e.busy = busy; e.irq_v = iv;
    e.chk_after = ca; e.irq_after = ia; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic drain(string req);
    wc(40);
    chk(req, "pending expected events", exp_q.size(), 0);
    exp_q.delete();
  endtask

  // generic condition: SCL low, SDA preset, SCL up for rel, SDA flips, hold, SCL down
  task automatic cond(bit to_stop, int rel, int hd);
    scl = 0; wc(4);
    sda = to_stop ? 1'b0 : 1'b1; wc(20);
    scl = 1; wc(rel);
    sda = to_stop ? 1'b1 : 1'b0; wc(hd);
    scl = 0; wc(4);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (after_pend) begin
        chk("R9", "irq one cycle after collision", irq, after_val);
        after_pend = 0;
      end
      if (start_pulse || stop_pulse) begin
        if (exp_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL %s unexpected pulse: actual start=%0b stop=%0b expected none",
                   cur_req, start_pulse, stop_pulse);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          chk(e.req, "pulse kind is stop", stop_pulse, e.is_stop);
          chk("R11", "both pulses", start_pulse && stop_pulse, 0);
          chk("R8", "bus_busy at pulse", bus_busy, e.busy);
          chk(e.is_stop ? "R9" : "R2", "irq at pulse", irq, e.irq_v);
          if (e.chk_after) begin
            after_pend = 1;
            after_val  = e.irq_after;
          end
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wc(5);
    chk("R1", "start_pulse in reset", start_pulse, 0);
    chk("R1", "stop_pulse in reset", stop_pulse, 0);
    chk("R1", "bus_busy in reset", bus_busy, 0);
    chk("R1", "irq in reset", irq, 0);
    rst_n = 1; wc(3);
    chk("R1", "bus_busy after reset", bus_busy, 0);
    chk("R1", "irq after reset", irq, 0);

    // R4: SCL-high time too short in standard mode
    cur_req = "R4"; cond(0, 18, 20); drain("R4");
    chk("R4", "bus_busy after short release", bus_busy, 0);

    // R2: good START
    cur_req = "R2"; push(0, 1, 0, 0, 0, "R2"); cond(0, 30, 20); drain("R2");

    // R12: data bits, SDA moves only while SCL low
    cur_req = "R12";
    for (int i = 0; i < 6; i++) begin
      scl = 0; wc(3); sda = i[0]; wc(3);
      scl = 1; wc(30); scl = 0; wc(3);
    end
    drain("R12");
    chk("R12", "bus_busy kept during data", bus_busy, 1);

    // R3 + R9: good STOP in slave mode
    cur_req = "R3"; push(1, 0, 1, 0, 0, "R3"); cond(1, 30, 20); drain("R3");
    chk("R9", "irq held without ack", irq, 1);
    ack = 1; wc(1); ack = 0; wc(2);
    chk("R9", "irq after ack", irq, 0);

    // R5: setup too short (SDA falls then rises within 6 cycles, SCL high long)
    cur_req = "R5";
    scl = 0; wc(4); sda = 1; wc(20); scl = 1; wc(40);
    sda = 0; wc(6); sda = 1; wc(20); scl = 0; wc(4);
    drain("R5");
    chk("R5", "bus_busy after short setup", bus_busy, 0);

    // R6: hold too short, SCL drops 7 cycles after edge
    cur_req = "R6"; cond(0, 40, 7); drain("R6");
    chk("R6", "bus_busy after short hold", bus_busy, 0);

    // R7: fast mode thresholds
    fast = 1;
    cur_req = "R7"; cond(0, 2, 6); drain("R7");
    chk("R7", "bus_busy after 2-cycle release", bus_busy, 0);
    cur_req = "R7"; cond(0, 8, 1); drain("R7");
    chk("R7", "bus_busy after 1-cycle hold", bus_busy, 0);
    push(0, 1, 0, 0, 0, "R7"); cond(0, 8, 6); drain("R7");

    // R10: master mode STOP, no interrupt
    mst = 1;
    cur_req = "R10"; push(1, 0, 0, 0, 0, "R10"); cond(1, 8, 6); drain("R10");
    chk("R10", "irq after master stop", irq, 0);
    mst = 0; fast = 0;

    // R9 collision: ack held high across the STOP
    cur_req = "R9"; push(0, 1, 0, 0, 0, "R9"); cond(0, 30, 20); drain("R9");
    ack = 1;
    push(1, 0, 1, 1, 0, "R9"); cond(1, 30, 20); drain("R9");
    ack = 0; wc(2);
    chk("R9", "irq after collision settles", irq, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule